// File: doc/BRIEF.md
# Wake and Interrupt Event Flag Register

An 8-bit register of sticky event flags that software can read and write. Each flag is set by hardware from one event source: a transfer-busy interrupt pulse, two firmware-collision pulses, an autowake-timer pulse, a rising edge of a pushbutton level, and a rising or falling edge of a PLL-ready level. Once set, a flag stays set until software writes a zero to its bit. Writing a one leaves the bit as it is. A sleep or LCD-mode request strobe also clears the pushbutton flag.

The pushbutton and autowake flags are loaded from a two-bit wake-cause input while reset is asserted. Boot code can therefore read why the part woke. The PLL-fall flag records only a real loss of power. It is never set for a part that comes out of reset with the PLL not ready, which is a wake into brownout caused by the pushbutton or the timer. When a hardware set and a clear (a software write or the low-power strobe) fall in the same cycle, the set wins. Reset is synchronous and active low.

Top module: `wake_event_flags`

## Requirements
- R1: Bit layout of `rd_data`: bit 0 transfer-busy, bit 1 reserved and always reads 0, bit 2 firmware-collision 0, bit 3 firmware-collision 1, bit 4 pushbutton, bit 5 autowake, bit 6 PLL-ready rose, bit 7 PLL-ready fell.
- R2: A clock edge with `rst_n` low loads bit 4 from `wake_cause[0]` and bit 5 from `wake_cause[1]`, and loads every other bit with 0.
- R3: A one-cycle high on `xfer_evt`, `fwcol_evt[0]`, `fwcol_evt[1]` or `autowake_evt` sets bit 0, 2, 3 or 5 at that clock edge. The flag then stays set after the pulse ends.
- R4: The pushbutton flag (bit 4) is set only by a low-to-high change of `btn`. A level held high does not set it again after a clear. A level held high through reset does not count as an edge.
- R5: A rise of `pll_ok` sets bit 6, and a fall of `pll_ok` sets bit 7. Each is seen at the edge where the new level is first sampled.
- R6: Bit 7 is never set unless `pll_ok` has been sampled high since reset was released, so waking into brownout does not set it.
- R7: A cycle with `wr_en` high clears every flag whose `wr_data` bit is 0 and leaves every flag whose `wr_data` bit is 1 unchanged.
- R8: A hardware set and a software clear of the same bit in the same cycle leave the bit set.
- R9: `lowpwr_req` clears bit 4 unless a pushbutton rising edge arrives in the same cycle. In that case the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_cause | input | 2 | Reset-time wake cause: bit 0 pushbutton, bit 1 timer |
| btn | input | 1 | Pushbutton level |
| pll_ok | input | 1 | PLL-ready level |
| xfer_evt | input | 1 | Transfer-busy interrupt pulse |
| fwcol_evt | input | 2 | Firmware-collision pulses |
| autowake_evt | input | 1 | Autowake timer pulse |
| lowpwr_req | input | 1 | Sleep or LCD-mode request strobe |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Software write data (0 clears, 1 keeps) |
| rd_data | output | 8 | Current flag values |

## Verification
Two functions can land in the same cycle: a hardware set and a clear of the same bit. The clear can come from a software write of zero or from the low-power strobe on the pushbutton flag. The bench raises a transfer-busy pulse in the same cycle as a write of 0x00, and a pushbutton rising edge in the same cycle as the low-power strobe. After that edge it expects the set bit to read 1 while the other cleared bits read 0. Both cases are also checked without the set event, to show that the clear alone takes effect.

// File: rtl/wake_event_flags.sv
module wake_event_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] wake_cause,
  input  logic       btn,
  input  logic       pll_ok,
  input  logic       xfer_evt,
  input  logic [1:0] fwcol_evt,
  input  logic       autowake_evt,
  input  logic       lowpwr_req,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);
  localparam logic [7:0] USED_MASK = 8'hFD;

  logic [7:0] flags;
  logic       btn_q;
  logic       pll_q;
  logic [7:0] hw_set;
  logic [7:0] clr;

  assign hw_set = {pll_q & ~pll_ok, pll_ok & ~pll_q, autowake_evt, btn & ~btn_q,
                   fwcol_evt[1], fwcol_evt[0], 1'b0, xfer_evt};
  assign clr    = (wr_en ? ~wr_data : 8'h00) | {3'b000, lowpwr_req, 4'b0000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= {2'b00, wake_cause[1], wake_cause[0], 4'h0};
      btn_q <= 1'b1;
      pll_q <= 1'b0;
    end else begin
      flags <= (hw_set | (flags & ~clr)) & USED_MASK;
      btn_q <= btn;
      pll_q <= pll_ok;
    end
  end

  assign rd_data = flags;
endmodule

module wake_event_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       btn,
  input logic       pll_ok,
  input logic       xfer_evt,
  input logic [1:0] fwcol_evt,
  input logic       lowpwr_req,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data
);
  logic pll_seen_high;

  always_ff @(posedge clk) begin
    if (!rst_n) pll_seen_high <= 1'b0;
    else if (pll_ok) pll_seen_high <= 1'b1;
  end

  // R3
  xfer_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_evt |=> rd_data[0]);

  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwcol_evt[1] && wr_en && !wr_data[3]) |=> rd_data[3]);

  // R7
  write_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[5] && rd_data[5]) |=> rd_data[5]);

  // R7
  write_zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[2] && !fwcol_evt[0]) |=> !rd_data[2]);

  // R9
  lowpwr_clears_btn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lowpwr_req && !btn) |=> !rd_data[4]);

  // R6
  no_fall_without_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] |-> pll_seen_high);
endmodule

bind wake_event_flags wake_event_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .btn(btn), .pll_ok(pll_ok), .xfer_evt(xfer_evt),
  .fwcol_evt(fwcol_evt), .lowpwr_req(lowpwr_req), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data)
);

// File: tb/tb_wake_event_flags.sv
module tb_wake_event_flags;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] wake_cause = 2'b00;
  logic       btn = 1'b0;
  logic       pll_ok = 1'b0;
  logic       xfer_evt = 1'b0;
  logic [1:0] fwcol_evt = 2'b00;
  logic       autowake_evt = 1'b0;
  logic       lowpwr_req = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_event_flags dut (
    .clk(clk), .rst_n(rst_n), .wake_cause(wake_cause), .btn(btn), .pll_ok(pll_ok),
    .xfer_evt(xfer_evt), .fwcol_evt(fwcol_evt), .autowake_evt(autowake_evt),
    .lowpwr_req(lowpwr_req), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] cause, input logic pll, input logic b);
    @(negedge clk);
    rst_n = 1'b0; wake_cause = cause; pll_ok = pll; btn = b;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic test_reset();
    do_reset(2'b01, 1'b0, 1'b0); check("R2 wake by button", 8'h10);
    do_reset(2'b10, 1'b0, 1'b0); check("R2 wake by timer", 8'h20);
    do_reset(2'b00, 1'b0, 1'b0); check("R2 plain reset", 8'h00);
    idle(3); check("R2 idle after reset", 8'h00);
  endtask

  task automatic test_pulses();
    do_reset(2'b00, 1'b0, 1'b0);
    xfer_evt = 1'b1; @(negedge clk); xfer_evt = 1'b0;
    check("R3 xfer bit0", 8'h01);
    fwcol_evt = 2'b01; @(negedge clk); fwcol_evt = 2'b10; @(negedge clk); fwcol_evt = 2'b00;
    check("R3 collision bits 2,3", 8'h0D);
    autowake_evt = 1'b1; @(negedge clk); autowake_evt = 1'b0;
    idle(2); check("R3 autowake bit5 sticky", 8'h2D);
  endtask

  task automatic test_writes();
    sw_write(8'hFF); check("R7 write ones keeps", 8'h2D);
    sw_write(8'hF3); check("R7 clear bits 2,3", 8'h21);
    sw_write(8'h00); check("R7 clear all", 8'h00);
    sw_write(8'hFF); check("R1 reserved bit reads 0", 8'h00);
  endtask

  task automatic test_set_over_clear();
    xfer_evt = 1'b1; fwcol_evt = 2'b01; @(negedge clk); xfer_evt = 1'b0; fwcol_evt = 2'b00;
    check("R8 setup", 8'h05);
    xfer_evt = 1'b1; sw_write(8'h00); xfer_evt = 1'b0;
    check("R8 set wins over write zero", 8'h01);
  endtask

  task automatic test_button();
    do_reset(2'b00, 1'b0, 1'b1);
    idle(2); check("R4 held through reset no edge", 8'h00);
    btn = 1'b0; idle(1); btn = 1'b1; @(negedge clk);
    check("R4 rising edge sets", 8'h10);
    sw_write(8'hEF); idle(2); check("R4 held level no reset", 8'h00);
    btn = 1'b0; idle(1); btn = 1'b1; @(negedge clk);
    check("R4 second edge sets", 8'h10);
    lowpwr_req = 1'b1; @(negedge clk); lowpwr_req = 1'b0;
    check("R9 low-power clears button", 8'h00);
    btn = 1'b0; idle(1);
    btn = 1'b1; lowpwr_req = 1'b1; @(negedge clk); lowpwr_req = 1'b0;
    check("R9 edge wins over low-power", 8'h10);
    xfer_evt = 1'b1; lowpwr_req = 1'b1; @(negedge clk); xfer_evt = 1'b0; lowpwr_req = 1'b0;
    check("R9 low-power touches only bit4", 8'h01);
  endtask

  task automatic test_pll();
    do_reset(2'b01, 1'b0, 1'b0);
    idle(4); check("R6 brownout wake no fall flag", 8'h10);
    do_reset(2'b10, 1'b0, 1'b0);
    idle(4); check("R6 timer wake no fall flag", 8'h20);
    pll_ok = 1'b1; @(negedge clk);
    check("R5 rise sets bit6", 8'h60);
    idle(2); pll_ok = 1'b0; @(negedge clk);
    check("R5 fall sets bit7", 8'hE0);
    sw_write(8'h00); idle(2); check("R5 flags clear and stay", 8'h00);
  endtask

  initial begin
    test_reset();
    test_pulses();
    test_writes();
    test_set_over_clear();
    test_button();
    test_pll();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: expired, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule